// File: doc/BRIEF.md
# Fused Multiply-Add Special-Value Resolver

This combinational block sits in front of a double-precision fused multiply-add unit. It computes either `z + x*y` or, when the negate-product control is set, `z - x*y`. It sorts each 64-bit operand into one of six classes: zero, subnormal, normal, infinity, quiet NaN or signalling NaN. From those classes it decides whether the answer is already known. When it is known, the block delivers the final 64-bit encoding and an invalid-operation flag in the same cycle. When it is not, the block raises a flag that hands the operation to the arithmetic datapath.

The block sets the signs of special results from an effective product sign. That sign is the XOR of the x and y sign bits, inverted when the product is negated. When two zeros of opposite effective sign cancel exactly, the sign of the zero depends on the rounding mode. Normalizing subnormal operands, the multiply and add, and rounding all happen in later stages.

Top module: `fma_special_resolver`

## Requirements
- R1: When any operand is a signalling NaN (exponent all ones, fraction nonzero, fraction bit 51 clear), it is chosen ahead of every quiet NaN. Among signalling NaNs, z is chosen before x, and x before y.
- R2: A chosen signalling NaN produces `invalidOp`=1. The result is that operand with fraction bit 51 set; the sign and all other bits are unchanged.
- R3: When no operand is a signalling NaN, the first quiet NaN (fraction bit 51 set) in the order z, x, y is returned unchanged, with `invalidOp`=0.
- R4: A product of an infinity and a zero, in either order, gives the default NaN 0x7FF8000000000000 with `invalidOp`=1, whatever z is.
- R5: When the product is infinite and z is an infinity whose sign differs from the effective product sign, the result is the default NaN with `invalidOp`=1. The effective product sign is x.sign XOR y.sign XOR `negProd`.
- R6: In every other case with an infinite product, the result is an infinity (exponent all ones, fraction 0) carrying the effective product sign, with `invalidOp`=0.
- R7: When the product is finite, of any magnitude, and z is infinite, the result is an infinity with z's sign.
- R8: When the product is zero and z is a zero with the same sign as the effective product sign, the result is a zero with z's sign.
- R9: When the product is zero and z is a zero of the opposite sign, the result is +0 (all bits 0), or -0 (only bit 63 set) when `rndMode` is 2'b11 (round toward minus infinity).
- R10: When the product is zero and z is a nonzero finite value (normal or subnormal), the result is z bit for bit, with `invalidOp`=0.
- R11: `computeNeeded` is 1 exactly when no operand is a NaN, z is finite, and x and y are both finite and nonzero. Whenever it is 0, the result and `invalidOp` follow R1 to R10.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opZ | input | 64 | Addend z |
| opX | input | 64 | Multiplicand x |
| opY | input | 64 | Multiplier y |
| negProd | input | 1 | 1 selects z - x*y |
| rndMode | input | 2 | Rounding mode; 2'b11 is toward minus infinity |
| result | output | 64 | Final encoding when a special case applies |
| invalidOp | output | 1 | Invalid-operation flag |
| computeNeeded | output | 1 | Operation must go to the arithmetic datapath |

## Verification
The bench targets NaN priority. Two NaNs of the same kind in different slots catch a resolver that scans the operands in the wrong order. A signalling NaN placed after a quiet one catches a resolver that lets a quiet NaN win. Signed infinities and zeros are run with `negProd` both clear and set, because a design that ignores the negation flips the infinity sign or wrongly flags invalid on an infinity sum that is legal. Cancelling zeros are run under every rounding mode, because a wrong mode decode gives a zero of the wrong sign. Subnormal addends with a zero product check that z passes through untouched.

// File: rtl/fma_special_pkg.sv
package fma_special_pkg;
  parameter int EXP_W  = 11;
  parameter int FRAC_W = 52;
  localparam int WIDTH  = 1 + EXP_W + FRAC_W;
  localparam int QBIT   = FRAC_W - 1;
  localparam int NUM_OP = 3;

  typedef enum logic [2:0] {
    CL_ZERO, CL_DENORM, CL_NORMAL, CL_INF, CL_QNAN, CL_SNAN
  } fpClass_e;

  typedef enum logic [1:0] {SRC_Z = 2'd0, SRC_X = 2'd1, SRC_Y = 2'd2} opSel_e;

  typedef enum logic [2:0] {
    OUT_NAN_PASS, OUT_NAN_QUIET, OUT_DEFAULT, OUT_INF, OUT_ZERO, OUT_PASSZ, OUT_NONE
  } outKind_e;

  typedef struct packed {
    outKind_e kind;
    opSel_e   src;
    logic     sign;
    logic     invalid;
    logic     compute;
  } resolveStrobe_t;
endpackage

// File: rtl/fma_operand_classify.sv
module fma_operand_classify
  import fma_special_pkg::*;
(
  input  logic [WIDTH-1:0] operand,
  output fpClass_e         opClass,
  output logic             opSign
);
  logic [EXP_W-1:0]  expField;
  logic [FRAC_W-1:0] fracField;

  assign expField  = operand[WIDTH-2:FRAC_W];
  assign fracField = operand[FRAC_W-1:0];
  assign opSign    = operand[WIDTH-1];

  always_comb begin
    if (&expField) begin
      if (fracField == '0)    opClass = CL_INF;
      else if (fracField[QBIT]) opClass = CL_QNAN;
      else                    opClass = CL_SNAN;
    end else if (expField == '0) begin
      opClass = (fracField == '0) ? CL_ZERO : CL_DENORM;
    end else begin
      opClass = CL_NORMAL;
    end
  end
endmodule

// File: rtl/fma_special_ctrl.sv
module fma_special_ctrl
  import fma_special_pkg::*;
(
  input  fpClass_e       clsZ,
  input  fpClass_e       clsX,
  input  fpClass_e       clsY,
  input  logic           signZ,
  input  logic           signX,
  input  logic           signY,
  input  logic           negProd,
  input  logic [1:0]     rndMode,
  output resolveStrobe_t strobe
);
  logic effSign, prodInf, prodZero, infTimesZero, towardNegInf;

  assign effSign      = signX ^ signY ^ negProd;
  assign prodInf      = (clsX == CL_INF) || (clsY == CL_INF);
  assign prodZero     = (clsX == CL_ZERO) || (clsY == CL_ZERO);
  assign infTimesZero = prodInf && prodZero;
  assign towardNegInf = (rndMode == 2'b11);

  always_comb begin
    strobe = '{kind: OUT_NONE, src: SRC_Z, sign: 1'b0, invalid: 1'b0, compute: 1'b0};
    if (clsZ == CL_SNAN || clsX == CL_SNAN || clsY == CL_SNAN) begin
      strobe.kind    = OUT_NAN_QUIET;
      strobe.invalid = 1'b1;
      strobe.src     = (clsZ == CL_SNAN) ? SRC_Z : (clsX == CL_SNAN) ? SRC_X : SRC_Y;
    end else if (clsZ == CL_QNAN || clsX == CL_QNAN || clsY == CL_QNAN) begin
      strobe.kind = OUT_NAN_PASS;
      strobe.src  = (clsZ == CL_QNAN) ? SRC_Z : (clsX == CL_QNAN) ? SRC_X : SRC_Y;
    end else if (infTimesZero) begin
      strobe.kind    = OUT_DEFAULT;
      strobe.invalid = 1'b1;
    end else if (prodInf) begin
      if (clsZ == CL_INF && signZ != effSign) begin
        strobe.kind    = OUT_DEFAULT;
        strobe.invalid = 1'b1;
      end else begin
        strobe.kind = OUT_INF;
        strobe.sign = effSign;
      end
    end else if (clsZ == CL_INF) begin
      strobe.kind = OUT_INF;
      strobe.sign = signZ;
    end else if (prodZero) begin
      if (clsZ == CL_ZERO) begin
        strobe.kind = OUT_ZERO;
        strobe.sign = (signZ == effSign) ? signZ : towardNegInf;
      end else begin
        strobe.kind = OUT_PASSZ;
      end
    end else begin
      strobe.compute = 1'b1;
    end
  end
endmodule

// File: rtl/fma_special_dp.sv
module fma_special_dp
  import fma_special_pkg::*;
(
  input  logic [WIDTH-1:0] opZ,
  input  logic [WIDTH-1:0] opX,
  input  logic [WIDTH-1:0] opY,
  input  resolveStrobe_t   strobe,
  output logic [WIDTH-1:0] result
);
  localparam logic [WIDTH-1:0] QUIET_MASK  = {{(WIDTH-FRAC_W){1'b0}}, 1'b1, {QBIT{1'b0}}};
  localparam logic [WIDTH-1:0] DEFAULT_NAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {QBIT{1'b0}}};

  logic [WIDTH-1:0] picked;

  always_comb begin
    case (strobe.src)
      SRC_X:   picked = opX;
      SRC_Y:   picked = opY;
      default: picked = opZ;
    endcase
  end

  always_comb begin
    case (strobe.kind)
      OUT_NAN_PASS:  result = picked;
      OUT_NAN_QUIET: result = picked | QUIET_MASK;
      OUT_DEFAULT:   result = DEFAULT_NAN;
      OUT_INF:       result = {strobe.sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
      OUT_ZERO:      result = {strobe.sign, {(WIDTH-1){1'b0}}};
      OUT_PASSZ:     result = opZ;
      default:       result = '0;
    endcase
  end
endmodule

// File: rtl/fma_special_resolver.sv
module fma_special_resolver
  import fma_special_pkg::*;
(
  input  logic [63:0] opZ,
  input  logic [63:0] opX,
  input  logic [63:0] opY,
  input  logic        negProd,
  input  logic [1:0]  rndMode,
  output logic [63:0] result,
  output logic        invalidOp,
  output logic        computeNeeded
);
  logic [WIDTH-1:0] opArr [NUM_OP];
  fpClass_e         clsArr [NUM_OP];
  logic             signArr [NUM_OP];
  resolveStrobe_t   strobe;

  assign opArr[0] = opZ;
  assign opArr[1] = opX;
  assign opArr[2] = opY;

  for (genvar gi = 0; gi < NUM_OP; gi++) begin : g_cls
    fma_operand_classify u_cls (
      .operand (opArr[gi]),
      .opClass (clsArr[gi]),
      .opSign  (signArr[gi])
    );
  end

  fma_special_ctrl u_ctrl (
    .clsZ    (clsArr[0]),
    .clsX    (clsArr[1]),
    .clsY    (clsArr[2]),
    .signZ   (signArr[0]),
    .signX   (signArr[1]),
    .signY   (signArr[2]),
    .negProd (negProd),
    .rndMode (rndMode),
    .strobe  (strobe)
  );

  fma_special_dp u_dp (
    .opZ    (opZ),
    .opX    (opX),
    .opY    (opY),
    .strobe (strobe),
    .result (result)
  );

  assign invalidOp     = strobe.invalid;
  assign computeNeeded = strobe.compute;
endmodule

// File: rtl/fma_special_checker.sv
module fma_special_checker (
  input logic [63:0] opZ,
  input logic [63:0] opX,
  input logic [63:0] opY,
  input logic        negProd,
  input logic [1:0]  rndMode,
  input logic [63:0] result,
  input logic        invalidOp,
  input logic        computeNeeded
);
  function automatic logic isNan(input logic [63:0] v);
    return (&v[62:52]) && (v[51:0] != '0);
  endfunction
  function automatic logic isSpecialExp(input logic [63:0] v);
    return &v[62:52];
  endfunction

  logic known;
  assign known = !$isunknown({opZ, opX, opY, negProd, rndMode, result, invalidOp, computeNeeded});

  always_comb begin
    if (known) begin
      // R11: a hand-off to the datapath never also flags invalid
      a_r11_no_flag_on_compute: assert (!(computeNeeded && invalidOp));
      // R11: hand-off only for finite, non-NaN operands with a nonzero product
      a_r11_compute_operands: assert (!computeNeeded ||
        (!isSpecialExp(opZ) && !isSpecialExp(opX) && !isSpecialExp(opY) &&
         opX[62:0] != '0 && opY[62:0] != '0));
      // R2, R4, R5: an invalid outcome is always a quiet NaN
      a_r2_invalid_gives_qnan: assert (!invalidOp || (isNan(result) && result[51]));
      // R3: any NaN input yields a NaN result, never a hand-off
      a_r3_nan_in_nan_out: assert (!(isNan(opZ) || isNan(opX) || isNan(opY)) ||
        (isNan(result) && !computeNeeded));
      // R9: a zero product with a zero z gives a zero
      a_r9_zero_sum_is_zero: assert (!((opX[62:0] == '0 || opY[62:0] == '0) &&
        !isSpecialExp(opX) && !isSpecialExp(opY) && opZ[62:0] == '0) ||
        (result[62:0] == '0 && !invalidOp));
    end
  end
endmodule

bind fma_special_resolver fma_special_checker chk (.*);

// File: tb/fma_special_resolver_test.sv
module fma_special_resolver_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] opZ = '0, opX = '0, opY = '0;
  logic        negProd = 1'b0;
  logic [1:0]  rndMode = 2'b00;
  logic [63:0] result;
  logic        invalidOp, computeNeeded;
  int          nChecks = 0, nFails = 0, cycles = 0;

  localparam logic [63:0] PZ   = 64'h0000_0000_0000_0000;
  localparam logic [63:0] NZ   = 64'h8000_0000_0000_0000;
  localparam logic [63:0] PINF = 64'h7FF0_0000_0000_0000;
  localparam logic [63:0] NINF = 64'hFFF0_0000_0000_0000;
  localparam logic [63:0] ONE  = 64'h3FF0_0000_0000_0000;
  localparam logic [63:0] NONE = 64'hBFF0_0000_0000_0000;
  localparam logic [63:0] TWO  = 64'h4000_0000_0000_0000;
  localparam logic [63:0] QN   = 64'h7FF8_0000_0000_1234;
  localparam logic [63:0] QN2  = 64'hFFF8_0000_0000_0099;
  localparam logic [63:0] SN   = 64'h7FF0_0000_0000_0055;
  localparam logic [63:0] SNN  = 64'hFFF4_0000_0000_0001;
  localparam logic [63:0] DNAN = 64'h7FF8_0000_0000_0000;
  localparam logic [63:0] DEN  = 64'h0000_0000_0000_0123;

  fma_special_resolver uut (.*);

  always #2.5 clk = ~clk;
  always @(posedge clk) cycles <= cycles + 1;

  // Reference model: returns {compute, invalid, result}
  function automatic logic [65:0] model(input logic [63:0] z, x, y, input logic ng, input logic [1:0] rm);
    logic zS, zQ, zI, zZ, xS, xQ, xI, xZ, yS, yQ, yI, yZ, ps;
    zI = z[62:52] == 11'h7FF; xI = x[62:52] == 11'h7FF; yI = y[62:52] == 11'h7FF;
    zQ = zI && z[51]; xQ = xI && x[51]; yQ = yI && y[51];
    zS = zI && !z[51] && z[50:0] != 0; xS = xI && !x[51] && x[50:0] != 0; yS = yI && !y[51] && y[50:0] != 0;
    zI = zI && z[51:0] == 0; xI = xI && x[51:0] == 0; yI = yI && y[51:0] == 0;
    zZ = z[62:0] == 0; xZ = x[62:0] == 0; yZ = y[62:0] == 0;
    ps = x[63] ^ y[63] ^ ng;
    if (zS) return {2'b01, z | 64'h0008_0000_0000_0000};
    if (xS) return {2'b01, x | 64'h0008_0000_0000_0000};
    if (yS) return {2'b01, y | 64'h0008_0000_0000_0000};
    if (zQ) return {2'b00, z};
    if (xQ) return {2'b00, x};
    if (yQ) return {2'b00, y};
    if ((xI && yZ) || (xZ && yI)) return {2'b01, DNAN};
    if (xI || yI) begin
      if (zI && z[63] != ps) return {2'b01, DNAN};
      return {2'b00, ps, 11'h7FF, 52'h0};
    end
    if (zI) return {2'b00, z[63], 11'h7FF, 52'h0};
    if (xZ || yZ) begin
      if (zZ) return {2'b00, (z[63] == ps) ? z[63] : (rm == 2'b11), 63'h0};
      return {2'b00, z};
    end
    return {2'b10, 64'h0};
  endfunction

  task automatic check(input string tag);
    logic [65:0] exp, act;
    exp = model(opZ, opX, opY, negProd, rndMode);
    act = {computeNeeded, invalidOp, result};
    nChecks++;
    if (exp[65] ? !computeNeeded : (act != exp)) begin
      nFails++;
      $display("FAIL %s: z=%h x=%h y=%h neg=%b rm=%b actual={%b,%b,%h} expected={%b,%b,%h}",
               tag, opZ, opX, opY, negProd, rndMode, act[65], act[64], act[63:0],
               exp[65], exp[64], exp[63:0]);
    end
  endtask

  task automatic apply(input logic [63:0] z, x, y, input logic ng, input logic [1:0] rm, input string tag);
    @(negedge clk);
    opZ = z; opX = x; opY = y; negProd = ng; rndMode = rm;
    #1;
    check(tag);
  endtask

  function automatic logic [63:0] randOp();
    logic [63:0] v;
    logic [51:0] f;
    v[63] = 1'($urandom);
    f = {$urandom, $urandom};
    case ($urandom % 6)
      0: begin f[51] = 1'b0; if (f == 0) f[0] = 1'b1; v[62:0] = {11'h7FF, f}; end
      1: begin f[51] = 1'b1; v[62:0] = {11'h7FF, f}; end
      2: v[62:0] = {11'h7FF, 52'h0};
      3: v[62:0] = '0;
      4: begin if (f == 0) f[0] = 1'b1; v[62:0] = {11'h000, f}; end
      default: v[62:0] = {11'(1 + $urandom % 2046), f};
    endcase
    return v;
  endfunction

  initial begin
    void'($urandom(32'd20240607));
    #1;
    // reset state: all-zero inputs give +0 (R8)
    check("R8 reset");
    repeat (3) @(posedge clk);
    rst = 1'b0;

    apply(QN,  SN,  ONE, 1'b0, 2'b00, "R1 snan beats earlier qnan");
    apply(SN,  SNN, ONE, 1'b0, 2'b00, "R1 z snan first");
    apply(ONE, QN,  SNN, 1'b0, 2'b00, "R1 y snan beats x qnan");
    apply(ONE, SNN, SN,  1'b1, 2'b11, "R2 quiet keeps sign and payload");
    apply(ONE, QN,  QN2, 1'b0, 2'b00, "R3 x qnan before y");
    apply(QN2, QN,  PINF, 1'b0, 2'b00, "R3 z qnan first");
    apply(ONE, PINF, PZ, 1'b0, 2'b00, "R4 inf times zero");
    apply(NINF, NZ, NINF, 1'b1, 2'b11, "R4 zero times inf");
    apply(NINF, PINF, ONE, 1'b0, 2'b00, "R5 opposite infinities");
    apply(PINF, PINF, ONE, 1'b1, 2'b00, "R5 negated product");
    apply(ONE, PINF, ONE, 1'b1, 2'b00, "R6 negated infinite product");
    apply(PINF, NINF, NONE, 1'b0, 2'b00, "R6 same sign infinities");
    apply(NINF, PZ, ONE, 1'b0, 2'b00, "R7 zero product z inf");
    apply(PINF, ONE, TWO, 1'b1, 2'b00, "R7 finite product z inf");
    apply(NZ, PZ, ONE, 1'b1, 2'b00, "R8 same effective sign");
    apply(NZ, PZ, ONE, 1'b0, 2'b00, "R9 cancel nearest");
    apply(NZ, PZ, ONE, 1'b0, 2'b11, "R9 cancel toward minus inf");
    apply(PZ, NZ, ONE, 1'b0, 2'b10, "R9 cancel toward plus inf");
    apply(DEN, NZ, TWO, 1'b0, 2'b11, "R10 subnormal z passes");
    apply(NONE, DEN, PZ, 1'b1, 2'b00, "R10 normal z passes");
    apply(ONE, ONE, TWO, 1'b0, 2'b00, "R11 normal operands");
    apply(PZ, DEN, DEN, 1'b1, 2'b00, "R11 subnormal product");

    for (int i = 0; i < 4000; i++)
      apply(randOp(), randOp(), randOp(), 1'($urandom), 2'($urandom), "R11 random");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    wait (cycles > 100000);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule